// File: doc/BRIEF.md
# Sequential Integer Divider with Zero-Quotient Skip

This block computes the quotient or the remainder of two 64-bit integers for an execute pipeline. A single start strobe loads both operands with three control bits: signed or unsigned, quotient or remainder, and full 64-bit or 32-bit width. The unit then runs a restoring shift-and-subtract loop over a 128-bit accumulator. The upper half of the accumulator holds the partial remainder. The lower half holds the remaining dividend bits, and quotient bits enter it from the bottom.

Each busy cycle normally retires one quotient bit, so a full division takes 64 steps. Sometimes the partial remainder is zero and the next eight dividend bits still to be brought down are also zero. In that case the next eight quotient bits must be zero, and the unit takes all eight in one step. This skip is taken only while fewer than 56 bits have been retired. Small dividends, such as 32-bit operands, therefore finish much sooner.

Signed operands are reduced to magnitudes at load time, and the sign is restored when the result is formed. The result is registered and shown with a one-cycle done pulse.

Top module: `iter_divider`

## Requirements
- R1: While reset is held and after its release, busy_o and done_o are low and result_o is zero.
- R2: A start_i seen at a clock edge while busy_o is low is accepted: busy_o is high from the next cycle.
- R3: For unsigned 64-bit operation, the result is floor(a/d) when rem_sel_i is 0, and a mod d when rem_sel_i is 1.
- R4: For signed operation, the quotient has magnitude |a|/|d| and is negated when the operand signs differ. The remainder takes the sign of the dividend. Results wrap to 64 bits, so the most negative value divided by -1 gives 0x8000000000000000 with remainder 0.
- R5: When word_i is 1, only bits 31:0 of each operand are used. They are sign-extended when signed_i is 1 and zero-extended otherwise. Bits 31:0 of the result are extended back to 64 bits the same way.
- R6: A zero divisor (after any width reduction) gives a result of zero, with the same bounded latency as any other operation.
- R7: Each busy cycle retires one quotient bit unless a skip applies. With no skip, done_o rises 64 cycles after the accepting edge, and busy_o never lasts more than 64 cycles.
- R8: A step retires 8 zero quotient bits at once when three conditions hold: the retired count k is below 56, the partial remainder floor(|a|/2^(64-k)) mod d is zero (the unreduced prefix when d is zero), and bits 63-k down to 56-k of |a| are zero. Latency is the number of steps this rule gives.
- R9: done_o is high for exactly one cycle, on the same edge at which busy_o falls. result_o holds its value until the next completion.
- R10: start_i while busy_o is high is ignored: the running operation's result and timing are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start strobe, taken only when idle |
| dividend_i | input | 64 | Dividend operand |
| divisor_i | input | 64 | Divisor operand |
| signed_i | input | 1 | 1 = two's-complement operands |
| rem_sel_i | input | 1 | 1 = return remainder, 0 = quotient |
| word_i | input | 1 | 1 = 32-bit operation |
| busy_o | output | 1 | Division in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 64 | Registered result |

## Verification
busy_o is due one cycle after the accepting edge. done_o and result_o are due L cycles after it, where L is 64 with no skips and fewer when the skip rule of R8 applies. The bench keeps a behavioural model that, for every accepted operation, derives L and the expected result from integer arithmetic on the operands. The model advances on each rising edge, and busy_o, done_o and result_o are compared with it at every falling edge. Each operation's measured latency is also compared with L, and a start pulse is injected mid-run to confirm that it changes neither latency nor result.

// File: rtl/div_pkg.sv
// Shared types for the iterative divider.
// Assumes operand widths are even so a half-width (word) mode exists.
package div_pkg;

    // Operation attributes captured at start and held for the run
    typedef struct packed {
        logic sgn;     // two's-complement operation
        logic rem;     // remainder requested
        logic word;    // half-width operation
        logic a_neg;   // dividend was negative
        logic d_neg;   // divisor was negative
        logic d_zero;  // divisor magnitude was zero
    } div_ctrl_t;

endpackage

// File: rtl/div_operand_prep.sv
// Reduces one operand to its magnitude and a sign flag.
// In word mode only the low half is used, sign- or zero-extended.
// Purely combinational; assumes W is even.
module div_operand_prep #(
    parameter int W = 64
) (
    input  logic [W-1:0] opnd_i,
    input  logic         sgn_i,
    input  logic         word_i,
    output logic [W-1:0] mag_o,
    output logic         neg_o
);
    localparam int HALF = W / 2;

    logic [W-1:0] ext;

    // Width reduction with the selected extension
    always_comb begin
        if (word_i) begin
            if (sgn_i) ext = {{HALF{opnd_i[HALF-1]}}, opnd_i[HALF-1:0]};
            else       ext = {{HALF{1'b0}}, opnd_i[HALF-1:0]};
        end else begin
            ext = opnd_i;
        end
    end

    // Magnitude of the extended value
    always_comb begin
        neg_o = sgn_i & ext[W-1];
        mag_o = neg_o ? (~ext + W'(1)) : ext;
    end
endmodule

// File: rtl/div_shift_core.sv
// Restoring shift-and-subtract loop on a 2W-bit accumulator.
// The upper half holds the partial remainder. The lower half holds the
// remaining dividend bits, and quotient bits enter it from the bottom.
// A step retires SKIP_BITS zero quotient bits when the top W+SKIP_BITS
// accumulator bits are zero and the retired count leaves room for them.
// A zero divisor never subtracts, so the loop still ends after W bits.
module div_shift_core #(
    parameter int W         = 64,
    parameter int SKIP_BITS = 8,
    parameter bit SKIP_EN   = 1'b1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load_i,
    input  logic [W-1:0]   dvd_i,
    input  logic [W-1:0]   dsr_i,
    output logic           run_o,
    output logic           last_o,
    output logic [2*W-1:0] acc_next_o
);
    localparam int ACC_W      = 2 * W;
    localparam int CNT_W      = $clog2(W) + 1;
    localparam int SKIP_LIMIT = W - SKIP_BITS;

    logic             run_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_next;
    logic [ACC_W-1:0] acc_q;
    logic [W-1:0]     dsr_q;
    logic [ACC_W-1:0] shl;
    logic [ACC_W-1:0] step_acc;
    logic [W-1:0]     up;
    logic [W-1:0]     diff;
    logic             carry;
    logic             fits;
    logic             can_skip;

    // Single-bit restoring step, with the carry-out kept for large divisors
    always_comb begin
        carry    = acc_q[ACC_W-1];
        shl      = {acc_q[ACC_W-2:0], 1'b0};
        up       = shl[ACC_W-1:W];
        fits     = (|dsr_q) && (carry || (up >= dsr_q));
        diff     = up - dsr_q;
        step_acc = fits ? {diff, shl[W-1:1], 1'b1} : shl;
    end

    // Skip detector, present only when the variant is enabled
    generate
        if (SKIP_EN) begin : g_skip
            always_comb begin
                can_skip = run_q
                         && !(|acc_q[ACC_W-1:W-SKIP_BITS])
                         && (cnt_q < CNT_W'(SKIP_LIMIT));
            end
        end else begin : g_noskip
            always_comb can_skip = 1'b0;
        end
    endgenerate

    // Next accumulator, count, and the end-of-run flag
    always_comb begin
        acc_next_o = can_skip ? (acc_q << SKIP_BITS) : step_acc;
        cnt_next   = cnt_q + (can_skip ? CNT_W'(SKIP_BITS) : CNT_W'(1));
        last_o     = run_q && (cnt_next == CNT_W'(W));
        run_o      = run_q;
    end

    // Loop state: load on start, advance while running
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            cnt_q <= '0;
            acc_q <= '0;
            dsr_q <= '0;
        end else if (load_i) begin
            run_q <= 1'b1;
            cnt_q <= '0;
            acc_q <= {{W{1'b0}}, dvd_i};
            dsr_q <= dsr_i;
        end else if (run_q) begin
            acc_q <= acc_next_o;
            cnt_q <= cnt_next;
            if (last_o) run_q <= 1'b0;
        end
    end
endmodule

// File: rtl/div_result_fix.sv
// Picks quotient or remainder, restores its sign, forces zero for a zero
// divisor, and extends half-width results. Purely combinational.
module div_result_fix
    import div_pkg::*;
#(
    parameter int W = 64
) (
    input  logic [W-1:0] quo_i,
    input  logic [W-1:0] rem_i,
    input  div_ctrl_t    ctrl_i,
    output logic [W-1:0] res_o
);
    localparam int HALF = W / 2;

    logic [W-1:0] raw;
    logic [W-1:0] signed_val;
    logic         flip;

    // Selection and sign restoration
    always_comb begin
        raw        = ctrl_i.rem ? rem_i : quo_i;
        flip       = ctrl_i.sgn & (ctrl_i.rem ? ctrl_i.a_neg
                                              : (ctrl_i.a_neg ^ ctrl_i.d_neg));
        signed_val = flip ? (~raw + W'(1)) : raw;
        if (ctrl_i.d_zero) signed_val = '0;
    end

    // Width extension for half-width operations
    always_comb begin
        if (ctrl_i.word) begin
            if (ctrl_i.sgn) res_o = {{HALF{signed_val[HALF-1]}}, signed_val[HALF-1:0]};
            else            res_o = {{HALF{1'b0}}, signed_val[HALF-1:0]};
        end else begin
            res_o = signed_val;
        end
    end
endmodule

// File: rtl/iter_divider.sv
// Top of the sequential divider. Accepts a start only when idle,
// captures the operation attributes, runs the shift core, and registers
// the fixed-up result with a one-cycle done pulse.
// Assumes the operand inputs are valid in the cycle start_i is high.
module iter_divider
    import div_pkg::*;
#(
    parameter int W         = 64,
    parameter int SKIP_BITS = 8,
    parameter bit SKIP_EN   = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic [W-1:0] dividend_i,
    input  logic [W-1:0] divisor_i,
    input  logic         signed_i,
    input  logic         rem_sel_i,
    input  logic         word_i,
    output logic         busy_o,
    output logic         done_o,
    output logic [W-1:0] result_o
);
    logic [W-1:0]   a_mag;
    logic [W-1:0]   d_mag;
    logic           a_neg;
    logic           d_neg;
    logic           load;
    logic           run;
    logic           last;
    logic [2*W-1:0] acc_next;
    logic [W-1:0]   res_fixed;
    div_ctrl_t      ctrl_q;
    logic           done_q;
    logic [W-1:0]   res_q;

    div_operand_prep #(.W(W)) u_prep_a (
        .opnd_i (dividend_i),
        .sgn_i  (signed_i),
        .word_i (word_i),
        .mag_o  (a_mag),
        .neg_o  (a_neg)
    );

    div_operand_prep #(.W(W)) u_prep_d (
        .opnd_i (divisor_i),
        .sgn_i  (signed_i),
        .word_i (word_i),
        .mag_o  (d_mag),
        .neg_o  (d_neg)
    );

    // A start is taken only while the loop is idle
    always_comb load = start_i && !run;

    div_shift_core #(.W(W), .SKIP_BITS(SKIP_BITS), .SKIP_EN(SKIP_EN)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load),
        .dvd_i      (a_mag),
        .dsr_i      (d_mag),
        .run_o      (run),
        .last_o     (last),
        .acc_next_o (acc_next)
    );

    div_result_fix #(.W(W)) u_fix (
        .quo_i  (acc_next[W-1:0]),
        .rem_i  (acc_next[2*W-1:W]),
        .ctrl_i (ctrl_q),
        .res_o  (res_fixed)
    );

    // Capture the operation attributes at start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (load) begin
            ctrl_q.sgn    <= signed_i;
            ctrl_q.rem    <= rem_sel_i;
            ctrl_q.word   <= word_i;
            ctrl_q.a_neg  <= a_neg;
            ctrl_q.d_neg  <= d_neg;
            ctrl_q.d_zero <= ~|d_mag;
        end
    end

    // Register the result and raise done for one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            res_q  <= '0;
        end else begin
            done_q <= last;
            if (last) res_q <= res_fixed;
        end
    end

    assign busy_o   = run;
    assign done_o   = done_q;
    assign result_o = res_q;
endmodule

// File: rtl/div_checker.sv
// Protocol and timing checks for iter_divider, attached by bind.
// Run length is tracked with a counter rather than a long $past depth.
module div_checker #(
    parameter int W = 64
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start_i,
    input logic [W-1:0] divisor_i,
    input logic         busy_o,
    input logic         done_o,
    input logic [W-1:0] result_o
);
    logic [7:0] run_cnt;
    logic       zero_pend;

    // Count busy cycles of the current run
    always_ff @(posedge clk) begin
        if (!rst_n)      run_cnt <= '0;
        else if (busy_o) run_cnt <= run_cnt + 8'd1;
        else             run_cnt <= '0;
    end

    // Remember whether the accepted operation had an all-zero divisor input
    always_ff @(posedge clk) begin
        if (!rst_n)                  zero_pend <= 1'b0;
        else if (start_i && !busy_o) zero_pend <= (divisor_i == '0);
    end

    AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && !busy_o |=> busy_o); // R2

    AST_DIV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && zero_pend |-> result_o == '0); // R6

    AST_BOUNDED_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> run_cnt < 8'(W)); // R7

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R9

    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o && $past(busy_o)); // R9

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && start_i |=> busy_o || done_o); // R10
endmodule

bind iter_divider div_checker #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .divisor_i (divisor_i),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .result_o  (result_o)
);

// File: tb/iter_divider_test.sv
// Self-checking bench: behavioural reference advanced on each rising edge,
// compared with the outputs on every falling edge.
module iter_divider_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [63:0] a_in = '0;
    logic [63:0] d_in = '0;
    logic        sgn_in = 1'b0;
    logic        rem_in = 1'b0;
    logic        word_in = 1'b0;
    logic        busy_o;
    logic        done_o;
    logic [63:0] result_o;

    int checks = 0;
    int errors = 0;

    iter_divider uut (
        .clk(clk), .rst_n(rst_n), .start_i(start),
        .dividend_i(a_in), .divisor_i(d_in),
        .signed_i(sgn_in), .rem_sel_i(rem_in), .word_i(word_in),
        .busy_o(busy_o), .done_o(done_o), .result_o(result_o)
    );

    always #2 clk = ~clk;

    function automatic logic [63:0] ext_op(logic [63:0] x, bit s, bit w);
        if (w) return s ? {{32{x[31]}}, x[31:0]} : {32'd0, x[31:0]};
        return x;
    endfunction

    function automatic logic [63:0] mag_of(logic [63:0] x, bit s);
        return (s && x[63]) ? -x : x;
    endfunction

    function automatic logic [63:0] expect_of(logic [63:0] a, logic [63:0] d,
                                              bit s, bit r, bit w);
        logic [63:0] ea = ext_op(a, s, w);
        logic [63:0] ed = ext_op(d, s, w);
        logic [63:0] ma = mag_of(ea, s);
        logic [63:0] md = mag_of(ed, s);
        logic [63:0] v;
        if (md == 0) return 64'd0;
        if (r) begin
            v = ma % md;
            if (s && ea[63]) v = -v;
        end else begin
            v = ma / md;
            if (s && (ea[63] ^ ed[63])) v = -v;
        end
        if (w) v = s ? {{32{v[31]}}, v[31:0]} : {32'd0, v[31:0]};
        return v;
    endfunction

    function automatic int lat_of(logic [63:0] a, logic [63:0] d, bit s, bit w);
        logic [63:0] ma = mag_of(ext_op(a, s, w), s);
        logic [63:0] md = mag_of(ext_op(d, s, w), s);
        logic [63:0] pr;
        logic [63:0] nxt;
        int k = 0;
        int n = 0;
        while (k < 64) begin
            pr = (k == 0) ? 64'd0 : (ma >> (64 - k));
            if (md != 0) pr = pr % md;
            nxt = (ma << k) >> 56;
            if (k < 56 && pr == 0 && nxt == 0) k += 8;
            else k += 1;
            n++;
        end
        return n;
    endfunction

    function automatic string tag_of(logic [63:0] d, bit s, bit w);
        if (ext_op(d, s, w) == 0) return "R6";
        if (w) return "R5";
        if (s) return "R4";
        return "R3";
    endfunction

    // Reference model
    logic        m_busy = 1'b0;
    logic        m_done = 1'b0;
    logic [63:0] m_res = '0;
    logic [63:0] m_pend = '0;
    int          m_left = 0;
    string       m_tag = "R1";

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy <= 1'b0;
            m_done <= 1'b0;
            m_res  <= '0;
        end else begin
            m_done <= 1'b0;
            if (m_busy) begin
                if (m_left == 1) begin
                    m_busy <= 1'b0;
                    m_done <= 1'b1;
                    m_res  <= m_pend;
                end
                m_left <= m_left - 1;
            end else if (start) begin
                m_busy <= 1'b1;
                m_left <= lat_of(a_in, d_in, sgn_in, word_in);
                m_pend <= expect_of(a_in, d_in, sgn_in, rem_in, word_in);
                m_tag  <= tag_of(d_in, sgn_in, word_in);
            end
        end
    end

    task automatic check(bit ok, string req, string what,
                         logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            check(busy_o == m_busy, "R2", "busy", 64'(busy_o), 64'(m_busy));
            check(done_o == m_done, "R7", "done timing", 64'(done_o), 64'(m_done));
            check(result_o == m_res, m_tag, "result", result_o, m_res);
        end
    end

    task automatic run_op(logic [63:0] a, logic [63:0] d, bit s, bit r, bit w,
                          bit poke);
        int cyc = 0;
        int exp_lat = lat_of(a, d, s, w);
        logic [63:0] exp_res = expect_of(a, d, s, r, w);
        @(negedge clk);
        while (busy_o) @(negedge clk);
        #1;
        a_in = a; d_in = d; sgn_in = s; rem_in = r; word_in = w;
        start = 1'b1;
        @(negedge clk);
        #1 start = 1'b0;
        while (!done_o && cyc < 100) begin
            if (poke && cyc == 3) begin
                // R10: a start while busy must not disturb the run
                a_in = 64'd1; d_in = 64'd1; start = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        check(cyc == exp_lat, (exp_lat < 64) ? "R8" : "R7", "latency",
              64'(cyc), 64'(exp_lat));
        check(result_o == exp_res, poke ? "R10" : tag_of(d, s, w), "final result",
              result_o, exp_res);
        @(negedge clk);
        check(!done_o && !busy_o, "R9", "done after pulse",
              64'({busy_o, done_o}), 64'd0);
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!busy_o && !done_o && result_o == 0, "R1", "in reset",
              result_o, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy_o && !done_o && result_o == 0, "R1", "after reset",
              result_o, 64'd0);

        run_op(64'd100, 64'd7, 0, 0, 0, 0);                          // R3
        run_op(64'd100, 64'd7, 0, 1, 0, 0);                          // R3
        run_op(64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0001, 0, 0, 0, 0); // R3
        run_op(64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0001, 0, 1, 0, 0); // R3
        run_op(64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 0, 0, 0, 0);          // R7
        run_op(64'd0, 64'd5, 0, 0, 0, 0);                            // R8
        run_op(64'd5, 64'd0, 0, 0, 0, 0);                            // R6
        run_op(64'd5, 64'd0, 1, 1, 1, 0);                            // R6
        run_op(-64'd7, 64'd2, 1, 0, 0, 0);                           // R4
        run_op(-64'd7, 64'd2, 1, 1, 0, 0);                           // R4
        run_op(64'd7, -64'd2, 1, 1, 0, 0);                           // R4
        run_op(64'h8000_0000_0000_0000, -64'd1, 1, 0, 0, 0);         // R4
        run_op(64'h8000_0000_0000_0000, -64'd1, 1, 1, 0, 0);         // R4
        run_op(64'h1234_5678_8000_0000, 64'hFFFF_FFFF, 1, 0, 1, 0);  // R5
        run_op(64'hDEAD_BEEF_0000_0064, 64'hABCD_0000_0000_0009, 0, 1, 1, 0); // R5
        run_op(64'hDEAD_BEEF_8000_0000, 64'h0000_0000_0000_0003, 0, 0, 1, 0); // R5
        run_op(64'h0000_0000_0001_0000, 64'd3, 0, 0, 0, 1);          // R10
        for (int i = 0; i < 40; i++) begin
            logic [63:0] ra = {$urandom, $urandom};
            logic [63:0] rd = {$urandom, $urandom};
            if (i % 4 == 1) ra = ra >> ($urandom % 64);              // R8
            if (i % 4 == 2) rd = rd >> ($urandom % 64);
            run_op(ra, rd, i[0], i[1], i[2], 0);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule